// File: doc/BRIEF.md
# Grouped Interrupt Request Register Bank

This block holds the pending-request, per-input enable and priority-level state for a bank of interrupt groups. Each group takes up to four request inputs. The inputs arrive as strobes that have already been qualified for edge or level trigger mode. A strobe latches its request bit until software clears it. The first two groups are non-maskable. Any strobe into them raises a one-cycle pulse on a dedicated output. The remaining groups are maskable, and their state is offered to a separate priority resolver as flat request, enable and level vectors.

Software reaches the state through a byte-wide register window. Each group owns four consecutive byte addresses. Byte 0 shows pending and enabled-pending requests. Writes to byte 0 use a paired-bit rule: an upper-nibble bit picks whether a 1 in the matching lower-nibble bit sets or clears that request. Byte 1 carries the level and the enable mask. Reads return data and a valid flag one cycle after the read strobe.

Top module: `intreq_bank`

## Requirements
- R1: While reset is low and after it is released, every request bit is 0, every enable field is 4'hF, every level field is 0, and nmi_pulse and bus_rvalid are 0.
- R2: A 1 on req_strobe bit g*4+i sets request lane i of group g on the next clock edge. The bit stays set until software clears it and appears on grp_request bit g*4+i. grp_enable and grp_level use the same flat order, with 4 and 3 bits per group.
- R3: bus_addr[6:2] selects the group and bus_addr[1:0] selects the byte. Bytes 2 and 3 of any group, and every address of groups 31 and above, read as 0x00 and ignore writes.
- R4: Reading byte 0 of a maskable group (groups 2 to 30) returns the request nibble in bits 7:4 and request AND enable in bits 3:0.
- R5: Byte 1 of a maskable group holds the level in bits 6:4 and the enable mask in bits 3:0. Bit 7 reads 0. A write updates both fields, and they change on no other write.
- R6: A write to byte 0 of a maskable group works per lane i. If bit i+4 is 1 and bit i is 1, the request is set. If bit i+4 is 0 and bit i is 1, the request is cleared. If bit i is 0, the request is unchanged.
- R7: For groups 0 and 1, byte 0 reads the requests in bits 3:0 with bits 7:4 zero. Writing 1 to bit i clears lane i. Byte 1 reads 0 and ignores writes. Enable stays 4'hF and level stays 0.
- R8: nmi_pulse is high for exactly the one cycle after an edge at which a strobe reached group 0 or 1 and that group's request AND enable was then nonzero.
- R9: When a strobe and a software clear hit the same request bit in the same cycle, the bit ends up set.
- R10: bus_rvalid is high in the cycle after each cycle with bus_re high, and low otherwise. bus_rdata then holds the register value as it stood at the read edge, before any write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_strobe | input | 124 | Qualified request strobes, bit g*4+i for group g lane i |
| bus_addr | input | 7 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_re |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt pulse |
| grp_request | output | 124 | Pending request bits of every group |
| grp_enable | output | 124 | Enable masks of every group |
| grp_level | output | 93 | Priority levels, 3 bits per group |

## Verification
The embedded assertions watch several rules on every cycle. A strobe always leaves its bit set, which also covers a strobe that collides with a clear. Requests and configuration stay unchanged when neither a write nor a strobe touches them. The read-valid timing follows the read strobe, and no NMI pulse appears without a preceding strobe into a non-maskable group. Other rules can only be shown by the bench scenarios comparing register reads and output vectors against a reference model: the exact paired-bit outcome of each write, the masked read-back nibble, the dead bytes and out-of-range groups, and the reset contents.

// File: rtl/intreq_pkg.sv
// Package: shared constants of the grouped interrupt request bank.
// Assumes the register byte format is fixed (4 lanes, 3-bit level).
package intreq_pkg;
    localparam int LANES   = 4;
    localparam int LEVEL_W = 3;
    localparam logic [1:0] BYTE_REQ = 2'd0;
    localparam logic [1:0] BYTE_CFG = 2'd1;
endpackage

// File: rtl/intreq_nmi_slot.sv
// Module: request state of one non-maskable group.
// Strobes set lanes; a software write-one clears lanes; the strobe wins.
// Assumes enable is fixed all-ones, so any strobe yields a fire indication.
module intreq_nmi_slot
    import intreq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] strobe,
    input  logic             clr_we,
    input  logic [LANES-1:0] clr_mask,
    output logic [LANES-1:0] request,
    output logic             fire
);
    logic [LANES-1:0] req_next;

    // Next request value: software clear first, then hardware set on top.
    always_comb begin
        req_next = request;
        if (clr_we) req_next = req_next & ~clr_mask;
        req_next = req_next | strobe;
    end

    // Fire when a strobe arrives and the enabled request is nonzero.
    assign fire = (|strobe) && (|req_next);

    // Request register update.
    always_ff @(posedge clk) begin
        if (!rst_n) request <= '0;
        else        request <= req_next;
    end

    // R9
    nmi_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|strobe) |=> ((request & $past(strobe)) == $past(strobe)));
    // R7
    nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we && !(|strobe)) |=> $stable(request));
endmodule

// File: rtl/intreq_mask_slot.sv
// Module: request, enable and level state of one maskable group.
// Byte 0 writes follow the paired-bit set/clear rule; byte 1 writes load
// level and enable. Hardware strobes win over a same-cycle clear.
module intreq_mask_slot
    import intreq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LANES-1:0]   strobe,
    input  logic               wr_req,
    input  logic               wr_cfg,
    input  logic [7:0]         wdata,
    output logic [LANES-1:0]   request,
    output logic [LANES-1:0]   enable,
    output logic [LEVEL_W-1:0] level
);
    logic [LANES-1:0] sw_set;
    logic [LANES-1:0] sw_clr;
    logic [LANES-1:0] req_next;

    // Decode the paired-bit write into set and clear masks.
    always_comb begin
        sw_set = '0;
        sw_clr = '0;
        if (wr_req) begin
            sw_set = wdata[7:4] & wdata[3:0];
            sw_clr = ~wdata[7:4] & wdata[3:0];
        end
        req_next = ((request & ~sw_clr) | sw_set) | strobe;
    end

    // Request register update.
    always_ff @(posedge clk) begin
        if (!rst_n) request <= '0;
        else        request <= req_next;
    end

    // Level and enable configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= '1;
            level  <= '0;
        end else if (wr_cfg) begin
            enable <= wdata[3:0];
            level  <= wdata[6:4];
        end
    end

    // R2
    strobe_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|strobe) |=> ((request & $past(strobe)) == $past(strobe)));
    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_req && !(|strobe)) |=> $stable(request));
    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cfg |=> ($stable(level) && $stable(enable)));
endmodule

// File: rtl/intreq_bank.sv
// Module: grouped interrupt request register bank (top).
// Generates one slot per group (non-maskable for the first NUM_NMI groups),
// decodes the byte register window, registers read data and the NMI pulse.
// Assumes strobes are already trigger-qualified by the caller.
module intreq_bank
    import intreq_pkg::*;
#(
    parameter int NUM_GROUPS = 31,
    parameter int NUM_NMI    = 2,
    parameter int ADDR_W     = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_GROUPS*LANES-1:0]   req_strobe,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [7:0]                    bus_wdata,
    input  logic                          bus_we,
    input  logic                          bus_re,
    output logic [7:0]                    bus_rdata,
    output logic                          bus_rvalid,
    output logic                          nmi_pulse,
    output logic [NUM_GROUPS*LANES-1:0]   grp_request,
    output logic [NUM_GROUPS*LANES-1:0]   grp_enable,
    output logic [NUM_GROUPS*LEVEL_W-1:0] grp_level
);
    localparam int GSEL_W = ADDR_W - 2;
    localparam logic [GSEL_W-1:0] LAST_GRP = GSEL_W'(NUM_GROUPS - 1);
    localparam logic [GSEL_W-1:0] NMI_LIM  = GSEL_W'(NUM_NMI);

    logic [GSEL_W-1:0]  grp_sel;
    logic [1:0]         byte_sel;
    logic [LANES-1:0]   req_a [NUM_GROUPS];
    logic [LANES-1:0]   en_a  [NUM_GROUPS];
    logic [LEVEL_W-1:0] lvl_a [NUM_GROUPS];
    logic [NUM_GROUPS-1:0] fire_a;
    logic [7:0]         rd_next;

    assign grp_sel  = bus_addr[ADDR_W-1:2];
    assign byte_sel = bus_addr[1:0];

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic hit;
        assign hit = (grp_sel == GSEL_W'(g));
        if (g < NUM_NMI) begin : g_nmi
            intreq_nmi_slot u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .strobe   (req_strobe[g*LANES +: LANES]),
                .clr_we   (bus_we && hit && (byte_sel == BYTE_REQ)),
                .clr_mask (bus_wdata[3:0]),
                .request  (req_a[g]),
                .fire     (fire_a[g])
            );
            assign en_a[g]  = '1;
            assign lvl_a[g] = '0;
        end else begin : g_mask
            intreq_mask_slot u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .strobe  (req_strobe[g*LANES +: LANES]),
                .wr_req  (bus_we && hit && (byte_sel == BYTE_REQ)),
                .wr_cfg  (bus_we && hit && (byte_sel == BYTE_CFG)),
                .wdata   (bus_wdata),
                .request (req_a[g]),
                .enable  (en_a[g]),
                .level   (lvl_a[g])
            );
            assign fire_a[g] = 1'b0;
        end
        assign grp_request[g*LANES +: LANES]     = req_a[g];
        assign grp_enable[g*LANES +: LANES]      = en_a[g];
        assign grp_level[g*LEVEL_W +: LEVEL_W]   = lvl_a[g];
    end

    // Read multiplexer: format the addressed byte of the selected group.
    always_comb begin
        rd_next = 8'h00;
        if (grp_sel <= LAST_GRP) begin
            if (grp_sel < NMI_LIM) begin
                if (byte_sel == BYTE_REQ) rd_next = {4'h0, req_a[grp_sel]};
            end else if (byte_sel == BYTE_REQ) begin
                rd_next = {req_a[grp_sel], req_a[grp_sel] & en_a[grp_sel]};
            end else if (byte_sel == BYTE_CFG) begin
                rd_next = {1'b0, lvl_a[grp_sel], en_a[grp_sel]};
            end
        end
    end

    // Read data register with one-cycle valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= 8'h00;
        end else begin
            bus_rvalid <= bus_re;
            bus_rdata  <= bus_re ? rd_next : 8'h00;
        end
    end

    // NMI pulse register, one cycle per firing strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_pulse <= 1'b0;
        else        nmi_pulse <= |fire_a;
    end

    // R10
    read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |=> bus_rvalid);
    // R10
    idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> !bus_rvalid);
    // R8
    nmi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pulse |-> $past(|req_strobe[NUM_NMI*LANES-1:0]));
endmodule

// File: tb/intreq_bank_tb.sv
// Bench: directed corner cases plus seeded random traffic, each cycle
// compared against a behavioural model of the register bank.
module intreq_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NG = 31;
    localparam int NB = NG * 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NB-1:0]  req_strobe = '0;
    logic [6:0]     bus_addr = '0;
    logic [7:0]     bus_wdata = '0;
    logic           bus_we = 1'b0;
    logic           bus_re = 1'b0;
    logic [7:0]     bus_rdata;
    logic           bus_rvalid;
    logic           nmi_pulse;
    logic [NB-1:0]  grp_request;
    logic [NB-1:0]  grp_enable;
    logic [NG*3-1:0] grp_level;

    int checks = 0;
    int errors = 0;

    logic [3:0] m_req [NG];
    logic [3:0] m_en  [NG];
    logic [2:0] m_lvl [NG];

    always #(CLK_PERIOD/2) clk = ~clk;

    intreq_bank dut_i (
        .clk(clk), .rst_n(rst_n), .req_strobe(req_strobe),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_re(bus_re), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .nmi_pulse(nmi_pulse), .grp_request(grp_request),
        .grp_enable(grp_enable), .grp_level(grp_level)
    );

    task automatic check(input string tag, input logic [NB-1:0] act,
                         input logic [NB-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [6:0] a);
        int g = int'(a[6:2]);
        if (g >= NG) return 8'h00;
        if (g < 2) return (a[1:0] == 2'd0) ? {4'h0, m_req[g]} : 8'h00;
        if (a[1:0] == 2'd0) return {m_req[g], m_req[g] & m_en[g]};
        if (a[1:0] == 2'd1) return {1'b0, m_lvl[g], m_en[g]};
        return 8'h00;
    endfunction

    task automatic model_write(input logic [6:0] a, input logic [7:0] d);
        int g = int'(a[6:2]);
        if (g >= NG) return;
        if (g < 2) begin
            if (a[1:0] == 2'd0) m_req[g] = m_req[g] & ~d[3:0];
        end else if (a[1:0] == 2'd0) begin
            m_req[g] = (m_req[g] & ~(~d[7:4] & d[3:0])) | (d[7:4] & d[3:0]);
        end else if (a[1:0] == 2'd1) begin
            m_lvl[g] = d[6:4];
            m_en[g]  = d[3:0];
        end
    endtask

    task automatic check_vectors(input string tag);
        logic [NB-1:0] er, ee, el;
        er = '0; ee = '0; el = '0;
        for (int g = 0; g < NG; g++) begin
            er[g*4 +: 4] = m_req[g];
            ee[g*4 +: 4] = m_en[g];
            el[g*3 +: 3] = m_lvl[g];
        end
        check({tag, " request vector"}, grp_request, er);
        check({tag, " enable vector"}, grp_enable, ee);
        check({tag, " level vector"}, NB'(grp_level), el);
    endtask

    // One bus/strobe cycle: drive at falling edge, check at next falling edge.
    task automatic step(input logic we, input logic re, input logic [6:0] a,
                        input logic [7:0] d, input logic [NB-1:0] s,
                        input string tag);
        logic [7:0] exp_rd;
        exp_rd = model_read(a);
        bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d; req_strobe = s;
        @(negedge clk);
        if (we) model_write(a, d);
        for (int g = 0; g < NG; g++) m_req[g] = m_req[g] | s[g*4 +: 4];
        check({tag, " R8 nmi_pulse"}, NB'(nmi_pulse), NB'(|s[7:0]));
        check({tag, " R10 rvalid"}, NB'(bus_rvalid), NB'(re));
        if (re) check({tag, " read data"}, NB'(bus_rdata), NB'(exp_rd));
        check_vectors(tag);
        bus_we = 1'b0; bus_re = 1'b0; req_strobe = '0;
    endtask

    function automatic logic [NB-1:0] one_bit(input int idx);
        logic [NB-1:0] v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1357);
        for (int g = 0; g < NG; g++) begin
            m_req[g] = 4'h0; m_en[g] = 4'hF; m_lvl[g] = 3'd0;
        end
        repeat (3) @(negedge clk);
        // R1: state during reset
        check("R1 nmi in reset", NB'(nmi_pulse), '0);
        check("R1 rvalid in reset", NB'(bus_rvalid), '0);
        check_vectors("R1 in reset");
        rst_n = 1'b1;
        step(1'b0, 1'b0, 7'd0, 8'h00, '0, "R1 after reset");
        // R5: default cfg of group 5 reads level 0 enable F
        step(1'b0, 1'b1, 7'd21, 8'h00, '0, "R5 default cfg read");
        // R2: strobe group 5 lane 2, then R4 read back
        step(1'b0, 1'b0, 7'd0, 8'h00, one_bit(5*4+2), "R2 strobe set");
        step(1'b0, 1'b1, 7'd20, 8'h00, '0, "R4 masked read");
        // R5: program level 3 enable 0101, read both bytes
        step(1'b1, 1'b0, 7'd21, 8'hB5, '0, "R5 cfg write");
        step(1'b0, 1'b1, 7'd21, 8'h00, '0, "R5 cfg read");
        step(1'b1, 1'b0, 7'd20, 8'hF3, '0, "R6 set lanes 0 1");
        step(1'b0, 1'b1, 7'd20, 8'h00, '0, "R4 masked read after set");
        step(1'b1, 1'b0, 7'd20, 8'h0B, '0, "R6 clear lanes 0 1 3");
        step(1'b0, 1'b1, 7'd20, 8'h00, '0, "R6 read after clear");
        // R3: dead bytes and out-of-range group
        step(1'b1, 1'b0, 7'd22, 8'hFF, '0, "R3 write byte 2");
        step(1'b1, 1'b0, 7'd23, 8'hFF, '0, "R3 write byte 3");
        step(1'b0, 1'b1, 7'd22, 8'h00, '0, "R3 read byte 2");
        step(1'b1, 1'b0, 7'd125, 8'h77, '0, "R3 write group 31");
        step(1'b0, 1'b1, 7'd124, 8'h00, '0, "R3 read group 31");
        // R7/R8: NMI group 0 lane 1
        step(1'b0, 1'b0, 7'd0, 8'h00, one_bit(1), "R8 nmi strobe");
        step(1'b0, 1'b1, 7'd0, 8'h00, '0, "R7 nmi read");
        step(1'b1, 1'b0, 7'd1, 8'h35, '0, "R7 nmi byte1 write");
        step(1'b0, 1'b1, 7'd1, 8'h00, '0, "R7 nmi byte1 read");
        step(1'b1, 1'b0, 7'd0, 8'h02, '0, "R7 nmi clear");
        step(1'b0, 1'b1, 7'd0, 8'h00, '0, "R7 nmi read cleared");
        // R9: strobe and clear collide on group 7 lane 0
        step(1'b1, 1'b0, 7'd28, 8'hF1, '0, "R9 preset");
        step(1'b1, 1'b0, 7'd28, 8'h01, one_bit(7*4), "R9 set wins");
        // R10: read and write same cycle returns old value
        step(1'b1, 1'b1, 7'd28, 8'h01, '0, "R10 read before write");
        // Random traffic
        for (int i = 0; i < 600; i++) begin
            logic [NB-1:0] s;
            logic [6:0] a;
            int op;
            s = '0;
            if ($urandom_range(1, 0) == 1) s = one_bit(int'($urandom_range(NB-1, 0)));
            a = 7'($urandom_range(127, 0));
            if ($urandom_range(1, 0) == 1) a = {a[6:2], 1'b0, a[0]};
            op = int'($urandom_range(2, 0));
            step(op == 1, op != 0, a, 8'($urandom_range(255, 0)), s,
                 "R2 R4 R5 R6 R7 random");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule